// File: doc/BRIEF.md
# Program Counter and Call/Branch Sequencer

This block is the program-flow unit of a small microcontroller whose instructions are 16-bit words. Each cycle it receives an already decoded flow operation and computes the next word address. It handles plain sequential advance, relative and absolute jumps, a conditional branch that tests one selected bit of the status word, a skip of the following instruction that tests one register bit, and subroutine call and return. Call and return move the return address through a byte-wide stack kept in data memory, which is addressed by a 16-bit stack pointer that counts downward.

Flow is governed by a four-state machine. `ST_RUN` accepts one operation per cycle. A call moves `ST_RUN -> ST_PUSH`, which writes one return-address byte per cycle and moves `ST_PUSH -> ST_RUN` after the last byte. A return moves `ST_RUN -> ST_POP`, which issues one read per cycle. After the last read it moves `ST_POP -> ST_POP_WAIT`, where the final byte arrives and the program counter is loaded, and then `ST_POP_WAIT -> ST_RUN`. In every state other than `ST_RUN` the unit reports busy, and the operation input is not used. The stack port is synchronous: read data appears one cycle after the read strobe.

Top module: `pcseq_top`

## Requirements
- R1: After reset, `pc_o` is 0, `sp_o` equals the parameter `SP_TOP` (default 16'h08FF), and `busy_o` is 0.
- R2: With `op_i`=0 (advance) in the run state, `pc_o` increases by one on the next edge.
- R3: With `op_i`=1 (relative jump), the new `pc_o` is pc + k + 1. Here k is `rel_off_i[11:0]` read as two's complement, and the sum wraps modulo 2^PC_W.
- R4: With `op_i`=2 (absolute jump), `pc_o` takes the low PC_W bits of the 22-bit `abs_tgt_i`.
- R5: With `op_i`=3 (conditional branch), when `status_i[flag_sel_i]` equals `flag_want_i`, the new `pc_o` is pc + k + 1, where k is `rel_off_i[6:0]` read as two's complement. Otherwise the new `pc_o` is pc + 1.
- R6: With `op_i`=4 (skip), when `rbit_i` equals `skip_if_set_i`, `pc_o` advances by 2, or by 3 if `next_long_i` is 1. Otherwise it advances by 1.
- R7: With `op_i`=5 (relative call), `pc_o` becomes pc + k + 1 (k as in R3) and the return address is pc + 1. With `op_i`=6 (absolute call), `pc_o` becomes the target as in R4 and the return address is pc + 2. In both cases `pc_o` changes on the edge that accepts the call.
- R8: After a call, the unit spends two cycles in the push state with `stk_we_o`=1. The first cycle writes the low byte of the return address at `sp_o`, the second writes the high byte, and `sp_o` decrements by one after each write.
- R9: With `op_i`=7 (return), the unit spends two read cycles with `stk_re_o`=1 at address `sp_o`+1, and `sp_o` increments after each read. The high byte is read first. One further cycle follows, at whose edge `pc_o` is loaded with {high, low}.
- R10: While `busy_o` is 1, `op_i` and the other operation inputs are ignored: `pc_o` changes only at the end of a return.
- R11: `stk_we_o` and `stk_re_o` are never both 1, and both are 0 while `busy_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 3 | Decoded flow operation (codes in R2 to R9) |
| rel_off_i | input | 12 | Signed relative offset; bits [6:0] serve branches |
| abs_tgt_i | input | 22 | Absolute jump or call target |
| flag_sel_i | input | 3 | Index of the status bit tested by a branch |
| flag_want_i | input | 1 | Value the tested status bit must have |
| status_i | input | 8 | Status word |
| rbit_i | input | 1 | Register bit tested by a skip |
| skip_if_set_i | input | 1 | 1: skip when bit set; 0: skip when bit clear |
| next_long_i | input | 1 | The instruction after a skip is two words |
| stk_addr_o | output | 16 | Stack memory byte address |
| stk_we_o | output | 1 | Stack write strobe |
| stk_re_o | output | 1 | Stack read strobe |
| stk_wdata_o | output | 8 | Stack write byte |
| stk_rdata_i | input | 8 | Stack read byte, valid one cycle after the read strobe |
| pc_o | output | 16 | Current word address |
| sp_o | output | 16 | Current stack pointer |
| busy_o | output | 1 | Unit is pushing or popping |

## Verification
The assertions assume four things about the inputs. `op_i` always carries a defined code. The stack memory returns read data exactly one cycle after `stk_re_o`. Every return is matched by an earlier call, so a pop only reads bytes that were pushed. The stack pointer never wraps through zero. The stimulus respects these limits: its random phase tracks call depth, caps it at eight, and issues a return only when the depth is nonzero. The memory model in the bench answers every read on the following edge. While the unit is busy, the bench deliberately drives stray jumps and returns to show that they are ignored.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

    typedef enum logic [2:0] {
        OP_NEXT   = 3'd0,
        OP_RJMP   = 3'd1,
        OP_JMP    = 3'd2,
        OP_BRANCH = 3'd3,
        OP_SKIP   = 3'd4,
        OP_RCALL  = 3'd5,
        OP_CALL   = 3'd6,
        OP_RET    = 3'd7
    } flow_op_e;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_PUSH,
        ST_POP,
        ST_POP_WAIT
    } seq_state_e;

endpackage

// File: rtl/pcseq_cond.sv
module pcseq_cond #(
    parameter int FLAG_W = 8,
    localparam int SEL_W = (FLAG_W > 1) ? $clog2(FLAG_W) : 1
) (
    input  logic [FLAG_W-1:0] status,
    input  logic [SEL_W-1:0]  sel,
    input  logic              want,
    input  logic              rbit,
    input  logic              on_set,
    output logic              flag_hit,
    output logic              bit_hit
);
    always_comb begin
        flag_hit = (status[sel] == want);
        bit_hit  = (rbit == on_set);
    end
endmodule

// File: rtl/pcseq_target.sv
module pcseq_target
    import pcseq_pkg::*;
#(
    parameter int PC_W  = 16,
    parameter int OFF_W = 12,
    parameter int BR_W  = 7,
    parameter int TGT_W = 22
) (
    input  logic [PC_W-1:0]  pc,
    input  flow_op_e         op,
    input  logic [OFF_W-1:0] rel_off,
    input  logic [TGT_W-1:0] abs_tgt,
    input  logic             flag_hit,
    input  logic             bit_hit,
    input  logic             next_long,
    output logic [PC_W-1:0]  nxt_pc,
    output logic [PC_W-1:0]  ret_addr
);
    logic [PC_W-1:0] rel_ext, br_ext, abs_pc, pc_one;

    always_comb begin
        rel_ext = {{(PC_W-OFF_W){rel_off[OFF_W-1]}}, rel_off};
        br_ext  = {{(PC_W-BR_W){rel_off[BR_W-1]}}, rel_off[BR_W-1:0]};
        abs_pc  = abs_tgt[PC_W-1:0];
        pc_one  = pc + PC_W'(1);
        ret_addr = (op == OP_CALL) ? pc + PC_W'(2) : pc_one;
        case (op)
            OP_RJMP, OP_RCALL: nxt_pc = pc_one + rel_ext;
            OP_JMP, OP_CALL:   nxt_pc = abs_pc;
            OP_BRANCH:         nxt_pc = flag_hit ? pc_one + br_ext : pc_one;
            OP_SKIP:           nxt_pc = !bit_hit ? pc_one
                                      : (next_long ? pc + PC_W'(3) : pc + PC_W'(2));
            OP_RET:            nxt_pc = pc;
            default:           nxt_pc = pc_one;
        endcase
    end
endmodule

// File: rtl/pcseq_fsm.sv
module pcseq_fsm
    import pcseq_pkg::*;
#(
    parameter int RA_BYTES = 2,
    localparam int IDX_W = (RA_BYTES > 1) ? $clog2(RA_BYTES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  flow_op_e         op,
    output seq_state_e       state,
    output logic [IDX_W-1:0] byte_idx,
    output logic             busy,
    output logic             is_push,
    output logic             is_pop,
    output logic             is_wait
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(RA_BYTES - 1);

    seq_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (op == OP_RCALL || op == OP_CALL) state_d = ST_PUSH;
                else if (op == OP_RET)               state_d = ST_POP;
            end
            ST_PUSH:     if (idx_q == LAST) state_d = ST_RUN;
            ST_POP:      if (idx_q == LAST) state_d = ST_POP_WAIT;
            ST_POP_WAIT: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) idx_q <= '0;
            else if (state_q == ST_PUSH || state_q == ST_POP) idx_q <= idx_q + IDX_W'(1);
        end
    end

    always_comb begin
        state    = state_q;
        byte_idx = idx_q;
        busy     = (state_q != ST_RUN);
        is_push  = (state_q == ST_PUSH);
        is_pop   = (state_q == ST_POP);
        is_wait  = (state_q == ST_POP_WAIT);
    end

    assert_push_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PUSH && idx_q == LAST) |=> state_q == ST_RUN);
    assert_pop_then_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_POP && idx_q == LAST) |=> state_q == ST_POP_WAIT);
    assert_wait_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_POP_WAIT) |=> state_q == ST_RUN);
endmodule

// File: rtl/pcseq_top.sv
module pcseq_top
    import pcseq_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int SP_W   = 16,
    parameter int OFF_W  = 12,
    parameter int BR_W   = 7,
    parameter int TGT_W  = 22,
    parameter int FLAG_W = 8,
    parameter logic [SP_W-1:0] SP_TOP = 16'h08FF,
    localparam int SEL_W    = (FLAG_W > 1) ? $clog2(FLAG_W) : 1,
    localparam int RA_BYTES = (PC_W + 7) / 8,
    localparam int RA_W     = RA_BYTES * 8,
    localparam int IDX_W    = (RA_BYTES > 1) ? $clog2(RA_BYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_i,
    input  logic [OFF_W-1:0]  rel_off_i,
    input  logic [TGT_W-1:0]  abs_tgt_i,
    input  logic [SEL_W-1:0]  flag_sel_i,
    input  logic              flag_want_i,
    input  logic [FLAG_W-1:0] status_i,
    input  logic              rbit_i,
    input  logic              skip_if_set_i,
    input  logic              next_long_i,
    output logic [SP_W-1:0]   stk_addr_o,
    output logic              stk_we_o,
    output logic              stk_re_o,
    output logic [7:0]        stk_wdata_o,
    input  logic [7:0]        stk_rdata_i,
    output logic [PC_W-1:0]   pc_o,
    output logic [SP_W-1:0]   sp_o,
    output logic              busy_o
);
    flow_op_e         op;
    seq_state_e       state;
    logic [IDX_W-1:0] byte_idx;
    logic             busy, is_push, is_pop, is_wait;
    logic             flag_hit, bit_hit;
    logic [PC_W-1:0]  nxt_pc, ret_addr;
    logic [PC_W-1:0]  pc_q;
    logic [SP_W-1:0]  sp_q;
    logic [RA_W-1:0]  ra_q, popped;
    logic             rd_pend_q;
    logic [7:0]       ra_byte [RA_BYTES];

    assign op = flow_op_e'(op_i);

    pcseq_cond #(.FLAG_W(FLAG_W)) u_cond (
        .status(status_i), .sel(flag_sel_i), .want(flag_want_i),
        .rbit(rbit_i), .on_set(skip_if_set_i),
        .flag_hit(flag_hit), .bit_hit(bit_hit)
    );

    pcseq_target #(.PC_W(PC_W), .OFF_W(OFF_W), .BR_W(BR_W), .TGT_W(TGT_W)) u_target (
        .pc(pc_q), .op(op), .rel_off(rel_off_i), .abs_tgt(abs_tgt_i),
        .flag_hit(flag_hit), .bit_hit(bit_hit), .next_long(next_long_i),
        .nxt_pc(nxt_pc), .ret_addr(ret_addr)
    );

    pcseq_fsm #(.RA_BYTES(RA_BYTES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .op(op), .state(state), .byte_idx(byte_idx),
        .busy(busy), .is_push(is_push), .is_pop(is_pop), .is_wait(is_wait)
    );

    for (genvar g = 0; g < RA_BYTES; g++) begin : g_ra_byte
        assign ra_byte[g] = ra_q[g*8 +: 8];
    end

    assign popped = (ra_q << 8) | RA_W'(stk_rdata_i);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q      <= '0;
            sp_q      <= SP_TOP;
            ra_q      <= '0;
            rd_pend_q <= 1'b0;
        end else begin
            rd_pend_q <= is_pop;
            if (rd_pend_q) ra_q <= popped;
            if (state == ST_RUN) begin
                pc_q <= nxt_pc;
                if (op == OP_RCALL || op == OP_CALL) ra_q <= RA_W'(ret_addr);
            end
            if (is_push) sp_q <= sp_q - SP_W'(1);
            if (is_pop)  sp_q <= sp_q + SP_W'(1);
            if (is_wait) pc_q <= popped[PC_W-1:0];
        end
    end

    always_comb begin
        stk_we_o    = is_push;
        stk_re_o    = is_pop;
        stk_addr_o  = is_push ? sp_q : sp_q + SP_W'(1);
        stk_wdata_o = ra_byte[byte_idx];
        pc_o        = pc_q;
        sp_o        = sp_q;
        busy_o      = busy;
    end

    assert_port_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(stk_we_o && stk_re_o));
    assert_port_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!stk_we_o && !stk_re_o));
    assert_push_sp_down_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stk_we_o |=> sp_o == $past(sp_o) - SP_W'(1));
    assert_pop_sp_up_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stk_re_o |=> sp_o == $past(sp_o) + SP_W'(1));
    assert_pc_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_we_o || stk_re_o) |=> $stable(pc_o));
    assert_call_pushes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && (op_i == 3'd5 || op_i == 3'd6)) |=> (stk_we_o && stk_addr_o == $past(sp_o)));
    assert_skip_miss_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && op_i == 3'd4 && rbit_i != skip_if_set_i) |=> pc_o == $past(pc_o) + PC_W'(1));
endmodule

// File: tb/pcseq_top_bench.sv
`timescale 1ns/1ps
module pcseq_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_i = 3'd0;
    logic [11:0] rel_off_i = '0;
    logic [21:0] abs_tgt_i = '0;
    logic [2:0]  flag_sel_i = '0;
    logic        flag_want_i = 1'b0;
    logic [7:0]  status_i = '0;
    logic        rbit_i = 1'b0, skip_if_set_i = 1'b0, next_long_i = 1'b0;
    logic [15:0] stk_addr_o;
    logic        stk_we_o, stk_re_o;
    logic [7:0]  stk_wdata_o, stk_rdata_i;
    logic [15:0] pc_o, sp_o;
    logic        busy_o;

    int checks = 0, errors = 0;
    logic [7:0] smem [int];

    always #4 clk = ~clk;

    pcseq_top u_pcseq_top (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .rel_off_i(rel_off_i), .abs_tgt_i(abs_tgt_i),
        .flag_sel_i(flag_sel_i), .flag_want_i(flag_want_i), .status_i(status_i),
        .rbit_i(rbit_i), .skip_if_set_i(skip_if_set_i), .next_long_i(next_long_i),
        .stk_addr_o(stk_addr_o), .stk_we_o(stk_we_o), .stk_re_o(stk_re_o),
        .stk_wdata_o(stk_wdata_o), .stk_rdata_i(stk_rdata_i),
        .pc_o(pc_o), .sp_o(sp_o), .busy_o(busy_o)
    );

    // stack memory: synchronous read, one cycle latency
    always @(posedge clk) begin
        if (stk_re_o) stk_rdata_i <= smem.exists(int'(stk_addr_o)) ? smem[int'(stk_addr_o)] : 8'h00;
        if (stk_we_o) smem[int'(stk_addr_o)] = stk_wdata_o;
    end

    // behavioural reference model
    int m_pc, m_sp, m_phase, m_cnt, m_ra, m_pop;
    int m_stk [int];
    string m_tag = "R1";

    function automatic int sx(int v, int bits);
        return ((v >> (bits - 1)) & 1) ? v - (1 << bits) : v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pc = 0; m_sp = 'h08FF; m_phase = 0; m_cnt = 0; m_ra = 0; m_tag = "R1";
        end else begin
            case (m_phase)
                0: begin
                    case (op_i)
                        3'd0: begin m_pc = m_pc + 1; m_tag = "R2"; end
                        3'd1: begin m_pc = m_pc + sx(int'(rel_off_i), 12) + 1; m_tag = "R3"; end
                        3'd2: begin m_pc = int'(abs_tgt_i); m_tag = "R4"; end
                        3'd3: begin
                            m_tag = "R5";
                            if (status_i[flag_sel_i] == flag_want_i) m_pc = m_pc + sx(int'(rel_off_i) & 'h7F, 7) + 1;
                            else m_pc = m_pc + 1;
                        end
                        3'd4: begin
                            m_tag = "R6";
                            if (rbit_i == skip_if_set_i) m_pc = m_pc + (next_long_i ? 3 : 2);
                            else m_pc = m_pc + 1;
                        end
                        3'd5: begin
                            m_ra = (m_pc + 1) & 'hFFFF; m_pc = m_pc + sx(int'(rel_off_i), 12) + 1;
                            m_phase = 1; m_cnt = 0; m_tag = "R7";
                        end
                        3'd6: begin
                            m_ra = (m_pc + 2) & 'hFFFF; m_pc = int'(abs_tgt_i);
                            m_phase = 1; m_cnt = 0; m_tag = "R7";
                        end
                        default: begin m_phase = 2; m_cnt = 0; m_pop = 0; m_tag = "R9"; end
                    endcase
                end
                1: begin
                    m_stk[m_sp] = (m_ra >> (8 * m_cnt)) & 'hFF;
                    m_sp = (m_sp - 1) & 'hFFFF; m_cnt++;
                    m_tag = "R8";
                    if (m_cnt == 2) m_phase = 0;
                end
                2: begin
                    m_sp = (m_sp + 1) & 'hFFFF;
                    m_pop = (m_pop << 8) | (m_stk.exists(m_sp) ? m_stk[m_sp] : 0);
                    m_cnt++;
                    if (m_cnt == 2) m_phase = 3;
                end
                default: begin m_pc = m_pop; m_phase = 0; m_tag = "R9"; end
            endcase
            m_pc = m_pc & 'hFFFF;
        end
    end

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        check(m_phase != 0 ? "R10" : m_tag, "pc", int'(pc_o), m_pc);
        check(m_phase == 1 ? "R8" : (m_phase == 0 ? m_tag : "R9"), "sp", int'(sp_o), m_sp);
        check("R10", "busy", int'(busy_o), int'(m_phase != 0));
        check(m_phase == 0 ? "R11" : "R8", "we", int'(stk_we_o), int'(m_phase == 1));
        check(m_phase == 0 ? "R11" : "R9", "re", int'(stk_re_o), int'(m_phase == 2));
        if (m_phase == 1) begin
            check("R8", "push addr", int'(stk_addr_o), m_sp);
            check("R8", "push byte", int'(stk_wdata_o), (m_ra >> (8 * m_cnt)) & 'hFF);
        end
        if (m_phase == 2) check("R9", "pop addr", int'(stk_addr_o), (m_sp + 1) & 'hFFFF);
    endtask

    task automatic cyc(input logic [2:0] op, input logic [11:0] off, input logic [21:0] tgt,
                       input logic [2:0] sel, input logic want, input logic [7:0] st,
                       input logic rb, input logic onset, input logic lng);
        @(negedge clk);
        compare_all();
        op_i = op; rel_off_i = off; abs_tgt_i = tgt; flag_sel_i = sel; flag_want_i = want;
        status_i = st; rbit_i = rb; skip_if_set_i = onset; next_long_i = lng;
    endtask

    task automatic simple(input logic [2:0] op, input logic [11:0] off, input logic [21:0] tgt);
        cyc(op, off, tgt, 3'd0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
    endtask

    // while busy, drive stray operations that must be ignored (R10)
    task automatic drain();
        while (m_phase != 0 || busy_o) begin
            @(negedge clk);
            compare_all();
            op_i = (m_cnt[0]) ? 3'd7 : 3'd2; abs_tgt_i = 22'h155AA; rel_off_i = 12'h333;
        end
    endtask

    initial begin
        int depth = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "reset pc", int'(pc_o), 0);
        check("R1", "reset sp", int'(sp_o), 'h08FF);
        check("R1", "reset busy", int'(busy_o), 0);
        rst_n = 1'b1;
        repeat (3) simple(3'd0, 12'h0, 22'h0);                 // R2
        simple(3'd1, 12'h005, 22'h0);                          // R3 forward
        simple(3'd1, 12'hFFD, 22'h0);                          // R3 backward
        simple(3'd1, 12'h800, 22'h0);                          // R3 most negative, wraps
        simple(3'd1, 12'h7FF, 22'h0);                          // R3 most positive
        simple(3'd2, 12'h0, 22'h3ABCD);                        // R4 upper bits dropped
        cyc(3'd3, 12'h010, 22'h0, 3'd1, 1'b1, 8'h02, 1'b0, 1'b0, 1'b0); // R5 taken
        cyc(3'd3, 12'h010, 22'h0, 3'd1, 1'b1, 8'hFD, 1'b0, 1'b0, 1'b0); // R5 not taken
        cyc(3'd3, 12'hF7F, 22'h0, 3'd3, 1'b0, 8'hF7, 1'b0, 1'b0, 1'b0); // R5 want 0, offset -1
        cyc(3'd3, 12'h040, 22'h0, 3'd7, 1'b1, 8'h80, 1'b0, 1'b0, 1'b0); // R5 offset -64
        cyc(3'd4, 12'h0, 22'h0, 3'd0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0);   // R6 skip one word
        cyc(3'd4, 12'h0, 22'h0, 3'd0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1);   // R6 skip two words
        cyc(3'd4, 12'h0, 22'h0, 3'd0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1);   // R6 no skip
        cyc(3'd4, 12'h0, 22'h0, 3'd0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);   // R6 skip on clear
        simple(3'd5, 12'h020, 22'h0); drain();                 // R7 relative call, R8 push
        simple(3'd6, 12'h0, 22'h01234); drain();               // R7 absolute call nested
        simple(3'd7, 12'h0, 22'h0); drain();                   // R9 return
        simple(3'd7, 12'h0, 22'h0); drain();                   // R9 return outer
        simple(3'd0, 12'h0, 22'h0);
        for (int i = 0; i < 300; i++) begin
            logic [2:0] op = 3'($urandom_range(0, 7));
            if (op == 3'd7 && depth == 0) op = 3'd0;
            if ((op == 3'd5 || op == 3'd6) && depth >= 8) op = 3'd1;
            if (op == 3'd5 || op == 3'd6) depth++;
            if (op == 3'd7) depth--;
            cyc(op, 12'($urandom), 22'($urandom), 3'($urandom), 1'($urandom), 8'($urandom),
                1'($urandom), 1'($urandom), 1'($urandom));
            drain();
        end
        while (depth > 0) begin simple(3'd7, 12'h0, 22'h0); drain(); depth--; end
        simple(3'd0, 12'h0, 22'h0);
        @(negedge clk); compare_all();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule